// File: doc/BRIEF.md
# Debug-Port Security Key Gate

This block decides whether a debug or monitor port may read and execute flash after power-up. Once power-on reset is released it lets a fixed start-up window pass. It then takes key bytes from a byte-level serial receiver and echoes each accepted byte back on the half-duplex line after a fixed delay. Each received byte is compared against the stored key byte with the same position. Only a complete match of all key bytes raises the unlock flag. The flash access logic uses that flag to grant read and execute access.

The unlock decision survives every reset except power-on. After a system reset that follows a finished key entry, the port is ready for commands at once and no new key is needed. After a system reset that comes before the entry has finished, the start-up window and the byte count begin again. Timing on the single wire is set by one parameter, the bit time in clock cycles. The echo comes two bit times after a byte is accepted. The receiver then stays deaf for one more bit time, and commands are held off for a fixed gap after the last echo.

Top module: `dbg_key_gate`

## Requirements
- R1: After power-on reset is released, a byte whose strobe is sampled on any of the first STARTUP_CYCLES (default 4128) rising edges is ignored: it produces no echo and is not counted. The first edge that can accept a byte is edge STARTUP_CYCLES+1.
- R2: An accepted byte is echoed once, with identical data on echo_data_o. echo_valid_o is high for exactly one cycle, 2*BIT_CYCLES cycles after the edge that sampled the byte.
- R3: A byte strobe is ignored (no echo, not counted) if it arrives while an echo is pending, or on any of the BIT_CYCLES edges that follow the echo edge. The byte at echo edge + BIT_CYCLES + 1 is accepted.
- R4: unlock_o is 0 after power-on reset. It rises with done_o only when the k-th accepted byte equals key_i[8k+7:8k] for every k from 0 to NUM_KEY-1.
- R5: A mismatch in any byte position leaves unlock_o at 0 and sets fail_o with done_o. fail_o and unlock_o are never high together.
- R6: done_o is a one-cycle pulse that coincides with the echo of the last key byte.
- R7: cmd_ready_o is 0 until key entry ends. It rises GAP_CYCLES (default 256) cycles after the last echo.
- R8: unlock_o and fail_o are cleared only by power-on reset. A system reset after a finished entry keeps them and sets cmd_ready_o on the next cycle, with no new key entry.
- R9: Byte strobes after key entry has finished produce no echo and do not change unlock_o or fail_o.
- R10: An all-0xFF stored key gets no special treatment: it unlocks only when eight 0xFF bytes are received.
- R11: A system reset before key entry finishes discards the bytes counted so far and restarts the start-up window from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_ni | input | 1 | Ordinary system reset, active low, sampled on the clock |
| rx_valid_i | input | 1 | Received-byte strobe from the serial receiver |
| rx_data_i | input | 8 | Received byte |
| key_i | input | 8*NUM_KEY | Stored key, byte k at bits 8k+7:8k |
| echo_valid_o | output | 1 | One-cycle request to transmit the echo byte |
| echo_data_o | output | 8 | Byte to echo |
| done_o | output | 1 | One-cycle pulse at the end of key entry |
| unlock_o | output | 1 | Flash read and execute access granted |
| fail_o | output | 1 | Key entry finished with a mismatch |
| cmd_ready_o | output | 1 | Monitor commands may be accepted |

## Verification
A wrong internal state shows up at the echo strobe first. A start-up or guard count that is one cycle off moves, adds or removes an echo within a few bit times of the affected byte. A wrong byte index or a lost mismatch bit stays hidden until the last echo. There it shows as the wrong choice between unlock_o and fail_o in the same cycle as done_o. Damage to the split-reset handling shows at cmd_ready_o and unlock_o on the cycle after a system reset, or when a power-on reset fails to clear them.

// File: rtl/dkg_pkg.sv
package dkg_pkg;
  typedef enum logic [2:0] {
    ST_BOOT,
    ST_IDLE,
    ST_ECHO,
    ST_GUARD,
    ST_GAP,
    ST_READY
  } dkg_state_e;
endpackage

// File: rtl/dkg_timer.sv
module dkg_timer #(
  parameter int unsigned CNT_W   = 13,
  parameter int unsigned RST_VAL = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= CNT_W'(RST_VAL);
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // expired timer stays expired until reloaded
  assert_zero_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/dkg_key_cmp.sv
module dkg_key_cmp #(
  parameter int unsigned NUM_KEY = 8,
  parameter int unsigned KCNT_W  = $clog2(NUM_KEY + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 take_i,
  input  logic [7:0]           byte_i,
  input  logic [8*NUM_KEY-1:0] key_i,
  output logic [KCNT_W-1:0]    count_o,
  output logic                 bad_o
);
  localparam int unsigned IDX_W = (NUM_KEY > 1) ? $clog2(NUM_KEY) : 1;

  logic [7:0]        key_bytes [NUM_KEY];
  logic [KCNT_W-1:0] count_q;
  logic              bad_q;
  logic [IDX_W-1:0]  idx;
  logic              differ;

  for (genvar k = 0; k < NUM_KEY; k++) begin : g_key_byte
    assign key_bytes[k] = key_i[8*k +: 8];
  end

  assign idx    = count_q[IDX_W-1:0];
  assign differ = (count_q < KCNT_W'(NUM_KEY)) ? (byte_i != key_bytes[idx]) : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      bad_q   <= 1'b0;
    end else if (clr_i) begin
      count_q <= '0;
      bad_q   <= 1'b0;
    end else if (take_i) begin
      count_q <= count_q + 1'b1;
      bad_q   <= bad_q | differ;
    end
  end

  assign count_o = count_q;
  assign bad_o   = bad_q;

  assert_count_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= KCNT_W'(NUM_KEY));
  assert_bad_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad_o && !clr_i) |=> bad_o);
endmodule

// File: rtl/dkg_seq.sv
module dkg_seq
  import dkg_pkg::*;
#(
  parameter int unsigned NUM_KEY        = 8,
  parameter int unsigned BIT_CYCLES     = 16,
  parameter int unsigned STARTUP_CYCLES = 4128,
  parameter int unsigned GAP_CYCLES     = 256,
  parameter int unsigned CNT_W          = 13,
  parameter int unsigned KCNT_W         = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_rst_ni,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              tmr_zero_i,
  input  logic [KCNT_W-1:0] key_cnt_i,
  input  logic              key_bad_i,
  output logic              tmr_load_o,
  output logic [CNT_W-1:0]  tmr_val_o,
  output logic              take_o,
  output logic              clr_o,
  output logic              echo_valid_o,
  output logic [7:0]        echo_data_o,
  output logic              done_o,
  output logic              unlock_o,
  output logic              fail_o,
  output logic              cmd_ready_o
);
  localparam logic [CNT_W-1:0] BOOT_LD  = CNT_W'(STARTUP_CYCLES - 1);
  localparam logic [CNT_W-1:0] ECHO_LD  = CNT_W'(2 * BIT_CYCLES - 1);
  localparam logic [CNT_W-1:0] GUARD_LD = CNT_W'(BIT_CYCLES - 1);
  localparam logic [CNT_W-1:0] GAP_LD   = CNT_W'(GAP_CYCLES - 1);

  dkg_state_e state_q, state_d;
  logic       unlock_q, fail_q, echo_q, done_q;
  logic [7:0] hold_q;
  logic       complete, last, echo_fire;

  assign complete  = unlock_q | fail_q;
  assign last      = (key_cnt_i == KCNT_W'(NUM_KEY));
  assign echo_fire = sys_rst_ni && (state_q == ST_ECHO) && tmr_zero_i;
  assign take_o    = sys_rst_ni && (state_q == ST_IDLE) && rx_valid_i;
  assign clr_o     = !sys_rst_ni && !complete;

  always_comb begin
    tmr_load_o = !sys_rst_ni || take_o || echo_fire;
    if (!sys_rst_ni)  tmr_val_o = BOOT_LD;
    else if (take_o)  tmr_val_o = ECHO_LD;
    else if (last)    tmr_val_o = GAP_LD;
    else              tmr_val_o = GUARD_LD;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_BOOT:  if (tmr_zero_i) state_d = ST_IDLE;
      ST_IDLE:  if (take_o) state_d = ST_ECHO;
      ST_ECHO:  if (tmr_zero_i) state_d = last ? ST_GAP : ST_GUARD;
      ST_GUARD: if (tmr_zero_i) state_d = ST_IDLE;
      ST_GAP:   if (tmr_zero_i) state_d = ST_READY;
      default:  state_d = ST_READY;
    endcase
    if (!sys_rst_ni) state_d = complete ? ST_READY : ST_BOOT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_BOOT;
      unlock_q <= 1'b0;
      fail_q   <= 1'b0;
      echo_q   <= 1'b0;
      done_q   <= 1'b0;
      hold_q   <= '0;
    end else begin
      state_q <= state_d;
      echo_q  <= echo_fire;
      done_q  <= echo_fire && last;
      if (take_o) hold_q <= rx_data_i;
      // verdict taken once, at the last echo
      if (echo_fire && last) begin
        unlock_q <= !key_bad_i;
        fail_q   <= key_bad_i;
      end
    end
  end

  assign echo_valid_o = echo_q;
  assign echo_data_o  = hold_q;
  assign done_o       = done_q;
  assign unlock_o     = unlock_q;
  assign fail_o       = fail_q;
  assign cmd_ready_o  = (state_q == ST_READY);

  assert_echo_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    echo_valid_o |=> !echo_valid_o);
  assert_done_on_echo_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> echo_valid_o);
  assert_unlock_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlock_o) |-> done_o);
  assert_verdict_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(unlock_o && fail_o));
  assert_unlock_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_o |=> unlock_o);
  assert_no_take_after_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    complete |-> !take_o);
  assert_ready_after_entry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> complete);
endmodule

// File: rtl/dbg_key_gate.sv
module dbg_key_gate #(
  parameter int unsigned NUM_KEY        = 8,
  parameter int unsigned BIT_CYCLES     = 16,
  parameter int unsigned STARTUP_CYCLES = 4128,
  parameter int unsigned GAP_CYCLES     = 256
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sys_rst_ni,
  input  logic                 rx_valid_i,
  input  logic [7:0]           rx_data_i,
  input  logic [8*NUM_KEY-1:0] key_i,
  output logic                 echo_valid_o,
  output logic [7:0]           echo_data_o,
  output logic                 done_o,
  output logic                 unlock_o,
  output logic                 fail_o,
  output logic                 cmd_ready_o
);
  localparam int unsigned MAX_A   = (STARTUP_CYCLES > 2 * BIT_CYCLES) ? STARTUP_CYCLES : 2 * BIT_CYCLES;
  localparam int unsigned MAX_CYC = (MAX_A > GAP_CYCLES) ? MAX_A : GAP_CYCLES;
  localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam int unsigned KCNT_W  = $clog2(NUM_KEY + 1);

  logic              tmr_load, tmr_zero, take, clr, key_bad;
  logic [CNT_W-1:0]  tmr_val;
  logic [KCNT_W-1:0] key_cnt;

  dkg_timer #(
    .CNT_W   (CNT_W),
    .RST_VAL (STARTUP_CYCLES - 1)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  dkg_key_cmp #(
    .NUM_KEY (NUM_KEY),
    .KCNT_W  (KCNT_W)
  ) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .take_i  (take),
    .byte_i  (rx_data_i),
    .key_i   (key_i),
    .count_o (key_cnt),
    .bad_o   (key_bad)
  );

  dkg_seq #(
    .NUM_KEY        (NUM_KEY),
    .BIT_CYCLES     (BIT_CYCLES),
    .STARTUP_CYCLES (STARTUP_CYCLES),
    .GAP_CYCLES     (GAP_CYCLES),
    .CNT_W          (CNT_W),
    .KCNT_W         (KCNT_W)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sys_rst_ni   (sys_rst_ni),
    .rx_valid_i   (rx_valid_i),
    .rx_data_i    (rx_data_i),
    .tmr_zero_i   (tmr_zero),
    .key_cnt_i    (key_cnt),
    .key_bad_i    (key_bad),
    .tmr_load_o   (tmr_load),
    .tmr_val_o    (tmr_val),
    .take_o       (take),
    .clr_o        (clr),
    .echo_valid_o (echo_valid_o),
    .echo_data_o  (echo_data_o),
    .done_o       (done_o),
    .unlock_o     (unlock_o),
    .fail_o       (fail_o),
    .cmd_ready_o  (cmd_ready_o)
  );

  // echo strobe only ever comes out before the entry has finished or on its last byte
  assert_echo_before_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    echo_valid_o |-> !cmd_ready_o);
endmodule

// File: tb/dbg_key_gate_tb_top.sv
module dbg_key_gate_tb_top;
  localparam int NK   = 8;
  localparam int BT   = 16;
  localparam int SU   = 4128;
  localparam int GAP  = 256;

  logic          clk = 1'b0;
  logic          por_n = 1'b0;
  logic          sys_n = 1'b1;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_data = '0;
  logic [8*NK-1:0] key = 64'h0123_4567_89AB_CDEF;
  logic          echo_valid, done, unlock, fail, cmd_ready;
  logic [7:0]    echo_data;

  int checks = 0;
  int failures = 0;
  int echo_seen = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  dbg_key_gate dut_i (
    .clk_i(clk), .rst_ni(por_n), .sys_rst_ni(sys_n),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .key_i(key),
    .echo_valid_o(echo_valid), .echo_data_o(echo_data), .done_o(done),
    .unlock_o(unlock), .fail_o(fail), .cmd_ready_o(cmd_ready)
  );

  // behavioural reference, timed by edge numbers since power-on release
  int         m_n, m_open, m_echo_at, m_bytes, m_ready_at;
  bit         m_bad, m_done_entry, m_unlock, m_fail, m_ready, m_echo, m_done;
  logic [7:0] m_echo_byte;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_n = 0; m_open = SU + 1; m_echo_at = -1; m_bytes = 0; m_ready_at = -1;
      m_bad = 0; m_done_entry = 0; m_unlock = 0; m_fail = 0; m_ready = 0;
      m_echo = 0; m_done = 0; m_echo_byte = '0;
    end else begin
      m_n++;
      m_echo = 0; m_done = 0;
      if (!sys_n) begin
        m_echo_at = -1;
        if (m_done_entry) m_ready = 1;
        else begin
          m_open = m_n + SU + 1; m_bytes = 0; m_bad = 0; m_ready_at = -1;
        end
      end else begin
        if (m_echo_at == m_n) begin
          m_echo = 1; m_echo_at = -1;
          if (m_bytes == NK) begin
            m_done = 1; m_done_entry = 1;
            if (m_bad) m_fail = 1; else m_unlock = 1;
            m_ready_at = m_n + GAP;
          end else m_open = m_n + BT + 1;
        end else if (!m_done_entry && m_echo_at < 0 && m_n >= m_open && rx_valid) begin
          if (rx_data != key[8*m_bytes +: 8]) m_bad = 1;
          m_bytes++;
          m_echo_byte = rx_data;
          m_echo_at = m_n + 2 * BT;
        end
        if (m_ready_at == m_n) m_ready = 1;
      end
    end
  end

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (por_n) begin
      check("R2", echo_valid, m_echo, "echo_valid_o");
      if (m_echo) check("R2", echo_data, m_echo_byte, "echo_data_o");
      check("R6", done, m_done, "done_o");
      check("R4", unlock, m_unlock, "unlock_o");
      check("R5", fail, m_fail, "fail_o");
      check("R7", cmd_ready, m_ready, "cmd_ready_o");
      if (echo_valid) echo_seen++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(logic [7:0] d);
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic power_on();
    @(negedge clk);
    por_n = 1'b0;
    wait_cyc(3);
    por_n = 1'b1;
    echo_seen = 0;
  endtask

  task automatic sys_reset();
    sys_n = 1'b0;
    @(negedge clk);
    sys_n = 1'b1;
  endtask

  // send a full key, byte k XORed with flip[k]; spacing meets the guard exactly
  task automatic send_key(logic [8*NK-1:0] flip);
    for (int k = 0; k < NK; k++) begin
      pulse(key[8*k +: 8] ^ flip[8*k +: 8]);
      wait_cyc(3 * BT);
    end
  endtask

  initial begin
    power_on();
    // R4 R7: reset state
    check("R4", unlock, 0, "unlock after power-on");
    check("R7", cmd_ready, 0, "cmd_ready after power-on");

    // R1: byte inside the start-up window
    wait_cyc(100);
    pulse(8'hEF);
    wait_cyc(3 * BT);
    check("R1", echo_seen, 0, "echo count inside start-up window");
    wait_cyc(SU);

    // R2 R3: first byte, then strobes in the echo wait and at the guard boundary
    pulse(key[7:0]);
    wait_cyc(5);
    pulse(8'h55);
    wait_cyc(3 * BT - 7);
    pulse(8'hAA);
    for (int k = 1; k < NK; k++) begin
      pulse(key[8*k +: 8]);
      wait_cyc(3 * BT);
    end
    wait_cyc(GAP + 4);
    check("R3", echo_seen, NK, "echo count with early strobes");
    check("R4", unlock, 1, "unlock after matching key");
    check("R7", cmd_ready, 1, "cmd_ready after gap");

    // R9: late bytes ignored
    pulse(8'h00);
    wait_cyc(3 * BT + 2);
    check("R9", echo_seen, NK, "echo count after entry");
    check("R9", unlock, 1, "unlock after late byte");

    // R8: system reset keeps unlock, ready at once
    sys_reset();
    check("R8", unlock, 1, "unlock after system reset");
    check("R8", cmd_ready, 1, "cmd_ready after system reset");

    // R5: mismatch in byte 3, then system reset keeps it locked
    power_on();
    check("R8", unlock, 0, "unlock cleared by power-on");
    wait_cyc(SU + 2);
    send_key(64'h0000_0000_0100_0000);
    wait_cyc(GAP + 4);
    check("R5", unlock, 0, "unlock after mismatch");
    check("R5", fail, 1, "fail after mismatch");
    sys_reset();
    check("R5", unlock, 0, "locked after system reset");
    check("R8", fail, 1, "fail kept through system reset");

    // R10: erased key, one byte off then exact
    key = '1;
    power_on();
    wait_cyc(SU + 2);
    send_key(64'h0000_0000_0000_0001);
    wait_cyc(GAP + 4);
    check("R10", unlock, 0, "erased key with wrong byte");
    power_on();
    wait_cyc(SU + 2);
    send_key('0);
    wait_cyc(GAP + 4);
    check("R10", unlock, 1, "erased key matched");

    // R11: system reset part way through entry restarts the window
    key = 64'hFEDC_BA98_7654_3210;
    power_on();
    wait_cyc(SU + 2);
    for (int k = 0; k < 3; k++) begin
      pulse(key[8*k +: 8]);
      wait_cyc(3 * BT);
    end
    sys_reset();
    pulse(key[7:0]);
    wait_cyc(3 * BT);
    check("R11", echo_seen, 3, "echo count after restart");
    wait_cyc(SU);
    send_key('0);
    wait_cyc(GAP + 4);
    check("R11", unlock, 1, "unlock after restarted entry");
    check("R11", echo_seen, 3 + NK, "total echoes");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule